// File: doc/BRIEF.md
# Noise-Filtered Timer Capture Channel

This block is a 16-bit timing channel that runs entirely from one system clock. A prescaler produces a count enable, and a free-running up-counter advances on each enable while the run input is high. Two trigger pins are each synchronized and passed through a small noise-rejecting edge filter. A trigger edge that survives the filter and matches the selected polarity copies the counter into that channel's capture/compare register. On the next prescaler tick, a one-cycle interrupt pulse follows. Either register can instead be set to compare mode. In compare mode it ignores its trigger and pulses a match flag when the counter passes its value.

Trigger pin 0 has a second role: it can serve as the count source in place of the prescaler. In that role it is sampled on every fourth system clock rather than on the prescaler tick. Register 0 then stops capturing. Register 0 also stops capturing when both polarities are selected on pin 0. Software writes to register 0 are dropped while the counter runs. Register 1 accepts writes at any time.

Each edge filter is a state machine with five states. INIT waits for the synchronizer to fill and then loads the settled level: SETTLE_DONE goes to LOW or HIGH. LOW goes to PEND_HI when a sample is high (FIRST_HI). PEND_HI goes to HIGH when the next sample is also high (CONFIRM_HI, which reports a rising edge). It returns to LOW when the next sample is low (REJECT_HI). HIGH, PEND_LO, FIRST_LO, CONFIRM_LO (which reports a falling edge) and REJECT_LO mirror this. Each capture/compare unit has two states. IDLE goes to PEND on a capture (CAPTURE). PEND returns to IDLE on the next prescaler tick, which emits the interrupt (NOTIFY).

Top module: `tmr_capture_chan`

## Requirements
- R1: After reset the counter, both registers, both interrupt outputs and both match outputs are zero.
- R2: Prescaler select 0,1,2,3,4 gives one count enable every 1,2,4,8,16 clocks, and codes 5 to 7 give every 16 clocks. The counter adds one per enable while run is high and wraps from 0xFFFF to 0.
- R3: A trigger passes two synchronizer flops. An edge is accepted only when two consecutive samples show the new level, so a pulse seen on one sample only is dropped. A level already present at reset produces no edge.
- R4: An accepted trigger edge in capture mode loads the register with the counter value held in the cycle of the confirming sample. With select 0, this is the counter value three clocks after the pin changes, taken at the clock just before the pin changed.
- R5: The interrupt pulse for a capture is one clock wide. It is asserted after the first prescaler tick that follows the capture.
- R6: Edge select codes per pin are 00 falling, 01 rising, 10 both, 11 off. On pin 1, the code for both edges captures on each edge, and off never captures.
- R7: With code 10 on pin 0, register 0 does not capture.
- R8: With the count-source flag set, pin 0 is sampled every 4 clocks. The counter adds one per accepted pin-0 edge of the selected polarity, and register 0 does not capture.
- R9: A register in compare mode (mode bit 1) ignores its trigger. It pulses its match output for one clock after a count enable at which the counter equalled the register, so the counter then reads the register value plus one.
- R10: A write to register 0 while run is high is ignored. A write to register 1 is taken at any time. An accepted write is visible one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Counter runs when high |
| presc_sel | input | 3 | Prescaler divide select |
| edge_sel0 | input | 2 | Polarity select for trigger pin 0 |
| edge_sel1 | input | 2 | Polarity select for trigger pin 1 |
| cmp_mode | input | 2 | Per register: 1 compare, 0 capture |
| cnt_from_in0 | input | 1 | Pin 0 edges drive the counter |
| trig_in | input | 2 | Asynchronous trigger pins |
| wr_en | input | 2 | Per-register write strobe |
| wr_data | input | 16 | Write data |
| cnt_val | output | 16 | Counter value |
| cc_val0 | output | 16 | Register 0 value |
| cc_val1 | output | 16 | Register 1 value |
| cap_irq | output | 2 | Per-register capture interrupt pulse |
| cmp_match | output | 2 | Per-register compare match pulse |

## Verification
The bench sends one-clock glitches that a filter with a single sample would accept, and checks that the register stays put. It checks the exact captured value and the one-clock lag of the interrupt; a design that latched on the first sample or fired the interrupt on the capture clock would be off by one there. It covers the cases that must block capture: both edges on pin 0, pin 0 as count source, and compare mode. A design that let any of these through would raise an unexpected interrupt. It also checks that register 0 writes are locked while running, the divide rates including the out-of-range codes, the counter wrap, and the position of the compare match.

// File: rtl/tmr_cap_pkg.sv
package tmr_cap_pkg;

    typedef enum logic [1:0] {
        EDG_FALL = 2'b00,
        EDG_RISE = 2'b01,
        EDG_BOTH = 2'b10,
        EDG_OFF  = 2'b11
    } edge_mode_e;

    typedef enum logic [2:0] {
        F_INIT,
        F_LOW,
        F_PEND_HI,
        F_HIGH,
        F_PEND_LO
    } filt_state_e;

    typedef enum logic {
        C_IDLE,
        C_PEND
    } cc_state_e;

    function automatic logic edge_hit(edge_mode_e m, logic r, logic f);
        logic hit;
        case (m)
            EDG_FALL: hit = f;
            EDG_RISE: hit = r;
            EDG_BOTH: hit = r | f;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W    = 3,
    parameter int MAX_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick,
    output logic             smp_div4
);
    localparam int DIV_W = MAX_LOG2;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    int               lg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    always_comb begin
        lg   = (int'(sel) > MAX_LOG2) ? MAX_LOG2 : int'(sel);
        mask = DIV_W'((32'd1 << lg) - 32'd1);
    end

    assign tick     = ((div_q & mask) == mask);
    assign smp_div4 = &div_q[1:0];

    // R2: divide-by-2 never ticks on two clocks in a row
    a_r2_div2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == 3'd1 && $past(sel) == 3'd1) |-> !$past(tick));

endmodule

// File: rtl/tmr_edge_filter.sv
module tmr_edge_filter
    import tmr_cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic smp_en,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(SYNC_STAGES + 1);
    localparam logic [CW-1:0] SETTLE = CW'(SYNC_STAGES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic [CW-1:0]          settle_q;
    filt_state_e            state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  settle_q <= '0;
        else if (state_q == F_INIT && settle_q != SETTLE) settle_q <= settle_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_INIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_INIT:    if (settle_q == SETTLE) state_d = lvl ? F_HIGH : F_LOW;
            F_LOW:     if (smp_en && lvl)      state_d = F_PEND_HI;
            F_PEND_HI: if (smp_en)             state_d = lvl ? F_HIGH : F_LOW;
            F_HIGH:    if (smp_en && !lvl)     state_d = F_PEND_LO;
            F_PEND_LO: if (smp_en)             state_d = lvl ? F_HIGH : F_LOW;
            default:                           state_d = F_INIT;
        endcase
    end

    // outputs
    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (state_q)
            F_PEND_HI: rise_o = smp_en && lvl;
            F_PEND_LO: fall_o = smp_en && !lvl;
            default: ;
        endcase
    end

    // R3: an edge is only reported on a sample at the new level
    a_r3_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (smp_en && lvl));
    a_r3_fall_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (smp_en && !lvl));
    a_r3_single_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));

endmodule

// File: rtl/tmr_cc_unit.sv
module tmr_cc_unit
    import tmr_cap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic         cnt_tick_i,
    input  logic         presc_tick_i,
    input  logic         cap_i,
    input  logic         cmp_mode_i,
    input  logic         wr_i,
    input  logic         wr_lock_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] val_o,
    output logic         irq_o,
    output logic         match_o
);
    logic [W-1:0] val_q;
    logic         irq_q, match_q;
    logic         cap_fire, wr_fire;
    cc_state_e    state_q, state_d;

    assign cap_fire = cap_i && !cmp_mode_i;
    assign wr_fire  = wr_i && !wr_lock_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        val_q <= '0;
        else if (wr_fire)  val_q <= wr_data_i;
        else if (cap_fire) val_q <= cnt_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: if (cap_fire) state_d = C_PEND;
            C_PEND: if (!cap_fire && presc_tick_i) state_d = C_IDLE;
            default: state_d = C_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            irq_q   <= (state_q == C_PEND) && presc_tick_i;
            match_q <= cmp_mode_i && cnt_tick_i && (cnt_i == val_q);
        end
    end

    assign val_o   = val_q;
    assign irq_o   = irq_q;
    assign match_o = match_q;

    // R5: interrupt follows a prescaler tick
    a_r5_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(presc_tick_i));
    // R9: compare mode holds the register unless written
    a_r9_cmp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode_i && !wr_fire) |=> $stable(val_q));
    a_r9_match_needs_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(cmp_mode_i));

endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan
    import tmr_cap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SEL_W       = 3,
    parameter int MAX_LOG2    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic [1:0]       edge_sel0,
    input  logic [1:0]       edge_sel1,
    input  logic [1:0]       cmp_mode,
    input  logic             cnt_from_in0,
    input  logic [1:0]       trig_in,
    input  logic [1:0]       wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cc_val0,
    output logic [CNT_W-1:0] cc_val1,
    output logic [1:0]       cap_irq,
    output logic [1:0]       cmp_match
);
    localparam int N_CH = 2;

    logic             presc_tick, smp_div4;
    logic [N_CH-1:0]  smp_w, rise_w, fall_w, capq_w;
    edge_mode_e       esel_w [N_CH];
    logic [CNT_W-1:0] ccv_w  [N_CH];
    logic [CNT_W-1:0] cnt_q;
    logic             ext_tick, cnt_tick;

    assign esel_w[0] = edge_mode_e'(edge_sel0);
    assign esel_w[1] = edge_mode_e'(edge_sel1);

    tmr_prescaler #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (presc_sel),
        .tick     (presc_tick),
        .smp_div4 (smp_div4)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        if (k == 0) begin : g_src
            assign smp_w[k]  = cnt_from_in0 ? smp_div4 : presc_tick;
            assign capq_w[k] = edge_hit(esel_w[k], rise_w[k], fall_w[k])
                               && !cnt_from_in0 && (esel_w[k] != EDG_BOTH);
        end else begin : g_plain
            assign smp_w[k]  = presc_tick;
            assign capq_w[k] = edge_hit(esel_w[k], rise_w[k], fall_w[k]);
        end

        tmr_edge_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (trig_in[k]),
            .smp_en (smp_w[k]),
            .rise_o (rise_w[k]),
            .fall_o (fall_w[k])
        );

        tmr_cc_unit #(.W(CNT_W)) u_cc (
            .clk          (clk),
            .rst_n        (rst_n),
            .cnt_i        (cnt_q),
            .cnt_tick_i   (cnt_tick),
            .presc_tick_i (presc_tick),
            .cap_i        (capq_w[k]),
            .cmp_mode_i   (cmp_mode[k]),
            .wr_i         (wr_en[k]),
            .wr_lock_i    ((k == 0) && run),
            .wr_data_i    (wr_data),
            .val_o        (ccv_w[k]),
            .irq_o        (cap_irq[k]),
            .match_o      (cmp_match[k])
        );
    end

    assign ext_tick = edge_hit(esel_w[0], rise_w[0], fall_w[0]);
    assign cnt_tick = run && (cnt_from_in0 ? ext_tick : presc_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_tick) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_val = cnt_q;
    assign cc_val0 = ccv_w[0];
    assign cc_val1 = ccv_w[1];

    // R2: counter wraps to zero
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && cnt_q == '1) |=> (cnt_val == '0));
    // R7: both-edge select on pin 0 blocks capture into register 0
    a_r7_both_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel0 == 2'b10 && !wr_en[0]) |=> $stable(cc_val0));
    // R8: pin 0 as count source blocks capture into register 0
    a_r8_src_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_from_in0 && !wr_en[0]) |=> $stable(cc_val0));
    // R10: running with capture blocked leaves register 0 untouched even on write
    a_r10_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (cnt_from_in0 || cmp_mode[0])) |=> $stable(cc_val0));

endmodule

// File: tb/test_tmr_capture_chan.sv
module test_tmr_capture_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [2:0]  presc_sel = 3'd0;
    logic [1:0]  edge_sel0 = 2'b01;
    logic [1:0]  edge_sel1 = 2'b01;
    logic [1:0]  cmp_mode = 2'b00;
    logic        cnt_from_in0 = 1'b0;
    logic [1:0]  trig_in = 2'b10;
    logic [1:0]  wr_en = 2'b00;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_val, cc_val0, cc_val1;
    logic [1:0]  cap_irq, cmp_match;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp0_q[$];
    logic [15:0] exp1_q[$];

    always #5 clk = ~clk;

    tmr_capture_chan i_tmr_capture_chan (
        .clk(clk), .rst_n(rst_n), .run(run), .presc_sel(presc_sel),
        .edge_sel0(edge_sel0), .edge_sel1(edge_sel1), .cmp_mode(cmp_mode),
        .cnt_from_in0(cnt_from_in0), .trig_in(trig_in), .wr_en(wr_en),
        .wr_data(wr_data), .cnt_val(cnt_val), .cc_val0(cc_val0),
        .cc_val1(cc_val1), .cap_irq(cap_irq), .cmp_match(cmp_match)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endfunction

    // scoreboard monitor: each interrupt pops the expected capture value (R4, R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (cap_irq[0]) begin
                if (exp0_q.size() == 0) check("R4 unexpected irq0", 32'(cc_val0), 32'hFFFF_FFFF);
                else check("R4 capture reg0", 32'(cc_val0), 32'(exp0_q.pop_front()));
            end
            if (cap_irq[1]) begin
                if (exp1_q.size() == 0) check("R4 unexpected irq1", 32'(cc_val1), 32'hFFFF_FFFF);
                else check("R4 capture reg1", 32'(cc_val1), 32'(exp1_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: drive pulse on pin k and push expected captures (valid for select 0, running)
    task automatic pulse(int k, int width, bit push_rise, bit push_fall);
        logic [15:0] v;
        v = cnt_val;
        trig_in[k] = 1'b1;
        if (push_rise) begin
            if (k == 0) exp0_q.push_back(v + 16'd3); else exp1_q.push_back(v + 16'd3);
        end
        wait_n(width);
        v = cnt_val;
        trig_in[k] = 1'b0;
        if (push_fall) begin
            if (k == 0) exp0_q.push_back(v + 16'd3); else exp1_q.push_back(v + 16'd3);
        end
        wait_n(10);
    endtask

    task automatic write_reg(int k, logic [15:0] d);
        wr_en[k] = 1'b1;
        wr_data  = d;
        wait_n(1);
        wr_en    = 2'b00;
    endtask

    initial begin
        logic [15:0] v, c;
        int m;
        wait_n(5);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 counter", 32'(cnt_val), 0);
        check("R1 reg0", 32'(cc_val0), 0);
        check("R1 reg1", 32'(cc_val1), 0);
        check("R1 irq", 32'(cap_irq), 0);
        check("R1 match", 32'(cmp_match), 0);
        // R3 pin 1 high through reset: no edge reported
        wait_n(12);
        check("R3 no edge at reset", 32'(cc_val1), 0);
        trig_in[1] = 1'b0;
        wait_n(10);
        check("R3 falling ignored with rising select", 32'(cc_val1), 0);

        run = 1'b1;
        wait_n(3);
        // R4/R5 directed timing on pin 0
        v = cnt_val;
        exp0_q.push_back(v + 16'd3);
        trig_in[0] = 1'b1;
        wait_n(4);
        check("R4 value after confirm", 32'(cc_val0), 32'(v + 16'd3));
        check("R5 no irq on capture clock", 32'(cap_irq[0]), 0);
        wait_n(1);
        check("R5 irq one tick later", 32'(cap_irq[0]), 1);
        wait_n(1);
        check("R5 irq one clock wide", 32'(cap_irq[0]), 0);
        wait_n(4);
        trig_in[0] = 1'b0;
        wait_n(10);

        pulse(1, 5, 1, 0);
        pulse(0, 3, 1, 0);

        // R3 single-sample glitch rejected
        c = cc_val1;
        trig_in[1] = 1'b1;
        wait_n(1);
        trig_in[1] = 1'b0;
        wait_n(10);
        check("R3 glitch rejected", 32'(cc_val1), 32'(c));

        // R6 polarity codes on pin 1
        edge_sel1 = 2'b00;
        pulse(1, 6, 0, 1);
        edge_sel1 = 2'b10;
        pulse(1, 8, 1, 1);
        edge_sel1 = 2'b11;
        c = cc_val1;
        pulse(1, 6, 0, 0);
        check("R6 off select holds", 32'(cc_val1), 32'(c));
        edge_sel1 = 2'b01;

        // R7 both edges on pin 0 blocks register 0
        edge_sel0 = 2'b10;
        c = cc_val0;
        pulse(0, 6, 0, 0);
        check("R7 both edges no capture", 32'(cc_val0), 32'(c));
        edge_sel0 = 2'b01;

        // R9 compare mode ignores trigger, then match position
        cmp_mode = 2'b10;
        c = cc_val1;
        pulse(1, 6, 0, 0);
        check("R9 compare ignores trigger", 32'(cc_val1), 32'(c));
        v = cnt_val + 16'd20;
        write_reg(1, v);
        check("R10 reg1 write while running", 32'(cc_val1), 32'(v));
        m = 0;
        for (int i = 0; i < 40; i++) begin
            if (cmp_match[1]) begin
                m++;
                check("R9 counter at match", 32'(cnt_val), 32'(v + 16'd1));
            end
            if (cmp_match[0]) check("R9 no match in capture mode", 1, 0);
            wait_n(1);
        end
        check("R9 single match", 32'(m), 1);
        cmp_mode = 2'b00;

        // R10 register 0 write lock
        c = cc_val0;
        write_reg(0, 16'hBEEF);
        check("R10 reg0 locked while running", 32'(cc_val0), 32'(c));
        run = 1'b0;
        write_reg(0, 16'hBEEF);
        check("R10 reg0 write when stopped", 32'(cc_val0), 32'hBEEF);
        run = 1'b1;

        // R8 pin 0 as count source
        cnt_from_in0 = 1'b1;
        wait_n(4);
        v = cnt_val;
        c = cc_val0;
        for (int i = 0; i < 5; i++) begin
            trig_in[0] = 1'b1;
            wait_n(12);
            trig_in[0] = 1'b0;
            wait_n(12);
        end
        wait_n(10);
        check("R8 counter follows pin 0", 32'(cnt_val), 32'(v + 16'd5));
        check("R8 reg0 no capture", 32'(cc_val0), 32'(c));
        cnt_from_in0 = 1'b0;

        // R2 prescaler rates
        for (int s = 0; s < 8; s++) begin
            int lg;
            if (s == 5 || s == 6) continue;
            lg = (s > 4) ? 4 : s;
            presc_sel = 3'(s);
            wait_n(20);
            v = cnt_val;
            wait_n(64);
            check("R2 divide rate", 32'(cnt_val - v), 32'(64 >> lg));
        end
        presc_sel = 3'd0;

        // R2 wrap
        m = 0;
        while (cnt_val != 16'hFFFF && m < 70000) begin
            wait_n(1);
            m++;
        end
        check("R2 reached max", 32'(cnt_val), 32'hFFFF);
        wait_n(1);
        check("R2 wrap to zero", 32'(cnt_val), 0);

        wait_n(5);
        check("R5 all expected irqs seen", 32'(exp0_q.size() + exp1_q.size()), 0);
        summary();
        $finish;
    end

endmodule